// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block translates a virtual page number into a physical page number by following a tree of page tables kept in memory. A walk starts from the root table, whose physical page number the requester supplies with each request; it comes from the running process context. At every level one 9-bit slice of the virtual page number picks one of 512 eight-byte entries in the current table, so each table fills one 4 KB page. A valid entry at an upper level points to the next table. The valid entry at the last level gives the physical page and its permission and history bits. An invalid entry at any level ends the walk with a fault, and the response says at which level the fault occurred.

A translation request enters on a valid/ready port. The block raises ready only when it is idle. While it is busy it holds ready low, so the requester keeps its request stalled. The result leaves on a valid/ready port. Once a result is offered, it stays stable until the consumer takes it, and the block accepts no new work until then. Memory is read through a single-outstanding port: the block holds its request and address until memory accepts them, then waits for exactly one data beat. The low 12 bits of an address are the page offset. They are never translated and do not appear on any port. The virtual address covers 48 bits and the physical address 40 bits.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are both 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the response handshake completes, and a request presented during that time has no effect on the walk in progress.
- R3: The entry address for a level is {current table page number (28 bits), 9-bit index, 3'b000}. Level 0 uses the root page number and `req_vpn[35:27]` (virtual address bits 47:39). Levels 1, 2 and 3 use `req_vpn[26:18]`, `[17:9]` and `[8:0]` in that order, each with the page number taken from the previous level's entry.
- R4: The entry layout is as follows. Bit 0 is valid. Bits [39:12] hold the page number: the next table for levels 0 to 2, and the translated page for level 3. On a level-3 entry, bit 1 is read permission, bit 2 is write permission, bit 3 is dirty and bit 4 is use.
- R5: An entry with bit 0 clear at level k ends the walk after that read with `rsp_fault`=1 and `rsp_fault_level`=k, and no further memory read is issued. On a fault, `rsp_ppn` and `rsp_flags` are 0.
- R6: A walk that meets no invalid entry issues exactly four memory reads. It responds with `rsp_fault`=0, `rsp_fault_level`=0, `rsp_ppn` = level-3 entry bits [39:12] and `rsp_flags` = level-3 entry bits [4:1] (flags bit 0 = read, 1 = write, 2 = dirty, 3 = use).
- R7: Once raised, `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. After an accepted read, no new read is requested until `mem_rsp_valid` returns the data.
- R8: While `rsp_valid` is high and `rsp_ready` is low, all response fields hold their values.
- R9: The root page number is sampled when the request is accepted. Changes on `req_root` during a walk do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_vpn | input | 36 | Virtual page number (virtual address bits 47:12) |
| req_root | input | 28 | Physical page number of the root table |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Walk met an invalid entry |
| rsp_fault_level | output | 2 | Level of the invalid entry (0 = root table) |
| rsp_ppn | output | 28 | Translated physical page number |
| rsp_flags | output | 4 | {use, dirty, write, read} of the last-level entry |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying read data |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
The hardest case to reach from the ports is an invalid entry placed exactly at one chosen level while both handshakes stall. It can coincide with memory refusing the read for several cycles and with the consumer holding back the result. The stimulus builds a fresh sparse table tree for every walk, placing valid entries along the path of the chosen virtual page number and an invalid one at a chosen depth (or none). Meanwhile the memory model toggles its ready at random, delays data by a random number of cycles, and the consumer holds its ready low for a random stretch. Directed walks cover a fault at each of the four levels. They also present a stray request during a busy walk and change the root input during a walk.

// File: rtl/pwalk_pkg.sv
package pwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_NEXT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  // Entry bit positions that the walk decodes
  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_FLAG_LSB  = 1;
  localparam int unsigned ENT_FLAG_W    = 4;

endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned VPN_W  = LEVELS * IDX_W,
  localparam int unsigned STEP_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [STEP_W-1:0] step,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] field [LEVELS];

  // Level 0 takes the most significant slice.
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign field[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (step == STEP_W'(i)) idx = field[i];
    end
  end

endmodule

// File: rtl/pw_entry_dec.sv
module pw_entry_dec
  import pwalk_pkg::*;
#(
  parameter int unsigned ENTRY_W  = 64,
  parameter int unsigned OFFSET_W = 12,
  parameter int unsigned PPN_W    = 28
) (
  input  logic [ENTRY_W-1:0]    entry,
  output logic                  ent_valid,
  output logic [PPN_W-1:0]      ent_ppn,
  output logic [ENT_FLAG_W-1:0] ent_flags
);

  assign ent_valid = entry[ENT_VALID_BIT];
  assign ent_ppn   = entry[OFFSET_W +: PPN_W];
  assign ent_flags = entry[ENT_FLAG_LSB +: ENT_FLAG_W];

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pwalk_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned ENT_LG = 3,
  parameter int unsigned PPN_W  = 28,
  localparam int unsigned VPN_W  = LEVELS * IDX_W,
  localparam int unsigned STEP_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned PA_W   = PPN_W + IDX_W + ENT_LG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VPN_W-1:0]      req_vpn,
  input  logic [PPN_W-1:0]      req_root,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_fault,
  output logic [STEP_W-1:0]     rsp_fault_level,
  output logic [PPN_W-1:0]      rsp_ppn,
  output logic [ENT_FLAG_W-1:0] rsp_flags,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic                  ent_valid,
  input  logic [PPN_W-1:0]      ent_ppn,
  input  logic [ENT_FLAG_W-1:0] ent_flags,
  output logic [VPN_W-1:0]      vpn_q,
  output logic [STEP_W-1:0]     step_q,
  input  logic [IDX_W-1:0]      idx
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LEVELS - 1);

  walk_state_e           state_q;
  logic [PPN_W-1:0]      base_q;
  logic [PPN_W-1:0]      ppn_q;
  logic [ENT_FLAG_W-1:0] flags_q;
  logic [STEP_W-1:0]     flt_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      vpn_q     <= '0;
      step_q    <= '0;
      ppn_q     <= '0;
      flags_q   <= '0;
      flt_lvl_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vpn_q     <= req_vpn;
          base_q    <= req_root;
          step_q    <= '0;
          ppn_q     <= '0;
          flags_q   <= '0;
          flt_lvl_q <= '0;
          state_q   <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!ent_valid) begin
            flt_lvl_q <= step_q;
            state_q   <= ST_FAULT;
          end else if (step_q == LAST_STEP) begin
            ppn_q   <= ent_ppn;
            flags_q <= ent_flags;
            state_q <= ST_DONE;
          end else begin
            base_q  <= ent_ppn;
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          step_q  <= step_q + 1'b1;
          state_q <= ST_ISSUE;
        end
        ST_DONE, ST_FAULT: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign mem_req_valid   = (state_q == ST_ISSUE);
  assign mem_req_addr    = {base_q, idx, {ENT_LG{1'b0}}};
  assign rsp_valid       = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault       = (state_q == ST_FAULT);
  assign rsp_fault_level = flt_lvl_q;
  assign rsp_ppn         = ppn_q;
  assign rsp_flags       = flags_q;

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid
      && $stable({rsp_fault, rsp_fault_level, rsp_ppn, rsp_flags}));

  assert_idle_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);

  assert_fault_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_ppn == '0 && rsp_flags == '0);

  assert_ok_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_fault_level == '0);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pwalk_pkg::*;
#(
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned ENTRY_W = 64,
  parameter int unsigned PA_W    = 40,
  localparam int unsigned ENT_LG   = $clog2(ENTRY_W / 8),
  localparam int unsigned OFFSET_W = IDX_W + ENT_LG,
  localparam int unsigned PPN_W    = PA_W - OFFSET_W,
  localparam int unsigned VPN_W    = LEVELS * IDX_W,
  localparam int unsigned STEP_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VPN_W-1:0]      req_vpn,
  input  logic [PPN_W-1:0]      req_root,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_fault,
  output logic [STEP_W-1:0]     rsp_fault_level,
  output logic [PPN_W-1:0]      rsp_ppn,
  output logic [ENT_FLAG_W-1:0] rsp_flags,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [ENTRY_W-1:0]    mem_rsp_data
);

  logic                  ent_valid;
  logic [PPN_W-1:0]      ent_ppn;
  logic [ENT_FLAG_W-1:0] ent_flags;
  logic [VPN_W-1:0]      vpn_q;
  logic [STEP_W-1:0]     step_q;
  logic [IDX_W-1:0]      idx;

  pw_entry_dec #(
    .ENTRY_W (ENTRY_W),
    .OFFSET_W(OFFSET_W),
    .PPN_W   (PPN_W)
  ) u_dec (
    .entry    (mem_rsp_data),
    .ent_valid(ent_valid),
    .ent_ppn  (ent_ppn),
    .ent_flags(ent_flags)
  );

  pw_index_sel #(
    .LEVELS(LEVELS),
    .IDX_W (IDX_W)
  ) u_idx (
    .vpn (vpn_q),
    .step(step_q),
    .idx (idx)
  );

  pw_ctrl #(
    .LEVELS(LEVELS),
    .IDX_W (IDX_W),
    .ENT_LG(ENT_LG),
    .PPN_W (PPN_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vpn        (req_vpn),
    .req_root       (req_root),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_fault      (rsp_fault),
    .rsp_fault_level(rsp_fault_level),
    .rsp_ppn        (rsp_ppn),
    .rsp_flags      (rsp_flags),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .ent_valid      (ent_valid),
    .ent_ppn        (ent_ppn),
    .ent_flags      (ent_flags),
    .vpn_q          (vpn_q),
    .step_q         (step_q),
    .idx            (idx)
  );

  // Walk bookkeeping observed from the ports, for checking only
  logic              rd_open_q;
  logic [STEP_W:0]   rd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_open_q <= 1'b0;
      rd_cnt_q  <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) rd_open_q <= 1'b1;
      else if (mem_rsp_valid)             rd_open_q <= 1'b0;
      if (req_valid && req_ready)              rd_cnt_q <= '0;
      else if (mem_req_valid && mem_req_ready) rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  assert_single_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open_q |-> !mem_req_valid);

  assert_four_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rd_cnt_q == (STEP_W+1)'(LEVELS));

  assert_fault_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rd_cnt_q == {1'b0, rsp_fault_level} + 1'b1);

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_vpn = '0;
  logic [27:0] req_root = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_fault_level;
  logic [27:0] rsp_ppn;
  logic [3:0]  rsp_flags;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_root(req_root),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
    .rsp_ppn(rsp_ppn), .rsp_flags(rsp_flags),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Sparse physical memory and read log
  logic [63:0] pmem [logic [39:0]];
  logic [39:0] rd_log [$];
  logic [39:0] exp_addr [$];
  bit          rand_ready = 1'b0;
  bit          pend = 1'b0;
  int          pend_dly = 0;
  logic [39:0] pend_addr = '0;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      rd_log.push_back(mem_req_addr);
      pend      = 1'b1;
      pend_addr = mem_req_addr;
      pend_dly  = $urandom % 3;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pmem.exists(pend_addr) ? pmem[pend_addr] : 64'd0;
        pend          = 1'b0;
      end else begin
        pend_dly--;
      end
    end
    mem_req_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] ent_addr(input logic [27:0] base,
                                           input logic [35:0] vpn, input int k);
    return {base, vpn[(3-k)*9 +: 9], 3'b000};
  endfunction

  // Build a path; an invalid entry at level fault_at (4 = none)
  task automatic build(input logic [35:0] vpn, input logic [27:0] root,
                       input int fault_at, input logic [3:0] leaf_flags);
    logic [27:0] base;
    logic [63:0] e;
    pmem.delete();
    base = root;
    for (int k = 0; k < 4; k++) begin
      e = {$urandom, $urandom};
      if (k == fault_at) begin
        e[0] = 1'b0;
        if ($urandom % 2 == 1) pmem[ent_addr(base, vpn, k)] = e;
        return;
      end
      e[0] = 1'b1;
      if (k == 3) e[4:1] = leaf_flags;
      pmem[ent_addr(base, vpn, k)] = e;
      base = e[39:12];
    end
  endtask

  // Expected result from the requirements
  task automatic model(input logic [35:0] vpn, input logic [27:0] root,
                       output bit f, output logic [1:0] lvl,
                       output logic [27:0] ppn, output logic [3:0] fl);
    logic [27:0] base;
    logic [63:0] e;
    logic [39:0] a;
    base = root; f = 1'b0; lvl = '0; ppn = '0; fl = '0;
    exp_addr.delete();
    for (int k = 0; k < 4; k++) begin
      a = ent_addr(base, vpn, k);
      exp_addr.push_back(a);
      e = pmem.exists(a) ? pmem[a] : 64'd0;
      if (!e[0]) begin
        f = 1'b1; lvl = 2'(k);
        return;
      end
      if (k == 3) begin
        ppn = e[39:12]; fl = e[4:1];
      end else begin
        base = e[39:12];
      end
    end
  endtask

  task automatic walk(input logic [35:0] vpn, input logic [27:0] root,
                      input int hold, input bit stray, input bit moveroot);
    bit          ef;
    logic [1:0]  el;
    logic [27:0] ep;
    logic [3:0]  efl;
    logic [63:0] snap;
    bit          stable_ok;
    model(vpn, root, ef, el, ep, efl);
    rd_log.delete();
    req_vpn = vpn; req_root = root; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (stray) req_vpn = ~vpn; else req_valid = 1'b0;
    if (moveroot) req_root = ~root;
    check(req_ready == 1'b0, "R2", "ready low while busy", 64'(req_ready), 64'd0);
    while (!rsp_valid) @(negedge clk);
    snap = {30'd0, rsp_fault, rsp_fault_level, rsp_flags, rsp_ppn};
    stable_ok = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if ({30'd0, rsp_fault, rsp_fault_level, rsp_flags, rsp_ppn} != snap || !rsp_valid)
        stable_ok = 1'b0;
    end
    if (hold > 0) check(stable_ok, "R8", "response held", 64'(stable_ok), 64'd1);
    check(rsp_fault == ef, ef ? "R5" : "R6", "fault", 64'(rsp_fault), 64'(ef));
    check(rsp_fault_level == (ef ? el : 2'd0), "R5", "fault level",
          64'(rsp_fault_level), 64'(ef ? el : 2'd0));
    check(rsp_ppn == ep, moveroot ? "R9" : "R6", "ppn", 64'(rsp_ppn), 64'(ep));
    check(rsp_flags == efl, "R4", "flags", 64'(rsp_flags), 64'(efl));
    rsp_ready = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rd_log.size() == exp_addr.size(), "R7", "read count",
          64'(rd_log.size()), 64'(exp_addr.size()));
    for (int i = 0; i < rd_log.size() && i < exp_addr.size(); i++)
      check(rd_log[i] == exp_addr[i], "R3", "entry address",
            64'(rd_log[i]), 64'(exp_addr[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] v;
    logic [27:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R5: directed fault at every level
    for (int k = 0; k < 4; k++) begin
      v = {$urandom, $urandom}; r = 28'($urandom);
      build(v, r, k, 4'hF);
      walk(v, r, 0, 1'b0, 1'b0);
    end
    // R4/R6: each flag pattern on a full walk
    for (int f = 0; f < 16; f++) begin
      v = {$urandom, $urandom}; r = 28'($urandom);
      build(v, r, 4, 4'(f));
      walk(v, r, f % 3, 1'b0, 1'b0);
    end
    // R2 stray request and R9 moving root, with stalls
    rand_ready = 1'b1;
    v = {$urandom, $urandom}; r = 28'($urandom);
    build(v, r, 4, 4'h5);
    walk(v, r, 4, 1'b1, 1'b1);
    v = 36'hF_FFFF_FFFF; r = 28'hFFF_FFFF;
    build(v, r, 3, 4'h0);
    walk(v, r, 2, 1'b1, 1'b1);
    v = '0; r = '0;
    build(v, r, 4, 4'hA);
    walk(v, r, 1, 1'b0, 1'b1);

    // Constrained random walks
    for (int n = 0; n < 300; n++) begin
      rand_ready = ($urandom % 2) == 1;
      v = {$urandom, $urandom}; r = 28'($urandom);
      build(v, r, int'($urandom % 6) > 4 ? 4 : int'($urandom % 5), 4'($urandom));
      walk(v, r, int'($urandom % 4), ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule